// File: doc/BRIEF.md
# Prescaled System Counter Bank

This block is a small word-addressed register bank for board-level timekeeping and simple I/O. A software-loaded reload value feeds a 32-bit down counter. Each time that down counter sits at zero, it reloads and a 32-bit event counter advances by one. Software can therefore read a time base at any rate it chooses. Two more up counters advance at 100 Hz and 1 Hz. Their ticks come from internal dividers sized from the `CLK_HZ` parameter.

The same bank holds a two-bit LED output register and an eight-bit control-line output register. It also presents two button inputs and eight switch inputs, each taken through a two-flop synchroniser. Writes are synchronous on `clk` when `wr_en` is high. Reads are combinational from `addr`. Addresses are word indices, so each one is a byte offset divided by four.

Top module: `sys_counter_bank`

## Requirements
- R1: While reset is held and directly after it, every register reads zero and `led_out` and `misc_out` are zero.
- R2: Word 0 is the LED register. Bits [1:0] drive `led_out` and are read back. Bits [31:2] read zero.
- R3: Word 19 is the control-line register. Bits [7:0] drive `misc_out` in this order: bit 0 LCD chip select, bit 1 shield-0 SPI select, bit 2 shield-1 SPI select, bit 3 LCD reset, bit 4 LCD register select, bit 5 LCD read strobe, bit 6 backlight, bit 7 ADC SPI select. Bits [31:8] read zero.
- R4: Word 2 returns `btn_in` in bits [1:0] and word 10 returns `sw_in` in bits [7:0]. An input change first shows in the read value after the second rising edge. Writes to these words have no effect.
- R5: Word 7 holds the 32-bit reload value. Word 8 is the live down counter. It decrements by one each cycle and, in a cycle where it is zero, loads the reload value at the next edge.
- R6: Word 6 is the event counter. It increments by exactly one on each edge where the down counter was zero and otherwise holds. With reload value N its period is N+1 cycles.
- R7: Word 5 increments once every CLK_HZ/100 cycles and word 4 once every CLK_HZ cycles. Both are writable.
- R8: A write to words 4, 5, 6 or 8 takes effect over the hardware update due on the same edge.
- R9: All other words read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| btn_in | input | 2 | Button inputs |
| sw_in | input | 8 | Switch inputs |
| led_out | output | 2 | LED outputs |
| misc_out | output | 8 | Control-line outputs |

## Verification
Two functions can land on the same edge: a software write to a counter, and that counter's own hardware step. These are the reload or increment when the down counter is at zero, and a 100 Hz tick. The bench lines a write up with the down-counter zero cycle by counting edges from a known write. It finds the tick phase by polling the 100 Hz counter until it changes, then writes exactly one divider period later. It judges the result by reading back the written value rather than the value plus one, and then checks that normal stepping resumes from it.

// File: rtl/sys_counter_bank.sv
module sys_counter_bank #(
  parameter int CLK_HZ = 1000,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [1:0]        btn_in,
  input  logic [7:0]        sw_in,
  output logic [1:0]        led_out,
  output logic [7:0]        misc_out
);
  localparam int DIV_FAST = CLK_HZ / 100;
  localparam int DIV_SLOW = CLK_HZ;
  localparam logic [ADDR_W-1:0] A_LED = 0, A_BTN = 2, A_SEC = 4, A_CENT = 5,
    A_EVT = 6, A_RLD = 7, A_DOWN = 8, A_SW = 10, A_MISC = 19;

  logic [1:0]  led_q, btn_m, btn_s;
  logic [7:0]  misc_q, sw_m, sw_s;
  logic [31:0] sec_q, cent_q, evt_q, rld_q, down_q, div_f, div_s;

  wire w_led  = wr_en && addr == A_LED;
  wire w_misc = wr_en && addr == A_MISC;
  wire w_sec  = wr_en && addr == A_SEC;
  wire w_cent = wr_en && addr == A_CENT;
  wire w_evt  = wr_en && addr == A_EVT;
  wire w_rld  = wr_en && addr == A_RLD;
  wire w_down = wr_en && addr == A_DOWN;

  wire at_zero   = down_q == 32'd0;
  wire tick_fast = div_f == 32'(DIV_FAST - 1);
  wire tick_slow = div_s == 32'(DIV_SLOW - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      led_q <= '0; misc_q <= '0; btn_m <= '0; btn_s <= '0; sw_m <= '0; sw_s <= '0;
      sec_q <= '0; cent_q <= '0; evt_q <= '0; rld_q <= '0; down_q <= '0;
      div_f <= '0; div_s <= '0;
    end else begin
      btn_m <= btn_in; btn_s <= btn_m;
      sw_m  <= sw_in;  sw_s  <= sw_m;
      div_f <= tick_fast ? '0 : div_f + 32'd1;
      div_s <= tick_slow ? '0 : div_s + 32'd1;
      if (w_led)  led_q  <= wdata[1:0];
      if (w_misc) misc_q <= wdata[7:0];
      if (w_rld)  rld_q  <= wdata;
      if (w_down)       down_q <= wdata;
      else if (at_zero) down_q <= rld_q;
      else              down_q <= down_q - 32'd1;
      if (w_evt)        evt_q <= wdata;
      else if (at_zero) evt_q <= evt_q + 32'd1;
      if (w_cent)         cent_q <= wdata;
      else if (tick_fast) cent_q <= cent_q + 32'd1;
      if (w_sec)          sec_q <= wdata;
      else if (tick_slow) sec_q <= sec_q + 32'd1;
    end
  end

  always_comb begin
    case (addr)
      A_LED:   rdata = {30'd0, led_q};
      A_BTN:   rdata = {30'd0, btn_s};
      A_SEC:   rdata = sec_q;
      A_CENT:  rdata = cent_q;
      A_EVT:   rdata = evt_q;
      A_RLD:   rdata = rld_q;
      A_DOWN:  rdata = down_q;
      A_SW:    rdata = {24'd0, sw_s};
      A_MISC:  rdata = {24'd0, misc_q};
      default: rdata = '0;
    endcase
  end

  assign led_out  = led_q;
  assign misc_out = misc_q;

  AST_EVT_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (at_zero && !w_evt) |=> evt_q == $past(evt_q) + 32'd1); // R6
  AST_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!at_zero && !w_evt) |=> $stable(evt_q)); // R6
  AST_DOWN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (at_zero && !w_down) |=> down_q == $past(rld_q)); // R5
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!at_zero && !w_down) |=> down_q == $past(down_q) - 32'd1); // R5
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (w_evt || w_down) |=> (evt_q == $past(wdata) || down_q == $past(wdata))); // R8
  AST_CENT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !w_cent |=> (cent_q == $past(cent_q) || cent_q == $past(cent_q) + 32'd1)); // R7
  AST_LED_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_LED) |-> rdata[1:0] == led_out); // R2
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_MISC) |-> rdata[31:8] == 24'd0); // R3
endmodule

// File: tb/sys_counter_bank_bench.sv
module sys_counter_bank_bench;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [9:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [1:0] btn_in = '0, led_out;
  logic [7:0] sw_in = '0, misc_out;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  sys_counter_bank #(.CLK_HZ(1000), .ADDR_W(10)) u_sys_counter_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .btn_in(btn_in), .sw_in(sw_in), .led_out(led_out), .misc_out(misc_out));

  // {addr, write data, expected read}
  localparam logic [73:0] VEC [7] = '{
    {10'd0,  32'hFFFF_FFFF, 32'h0000_0003},   // R2
    {10'd19, 32'hFFFF_FFFF, 32'h0000_00FF},   // R3
    {10'd19, 32'h0000_01A5, 32'h0000_00A5},   // R3
    {10'd7,  32'hDEAD_BEEF, 32'hDEAD_BEEF},   // R5
    {10'd0,  32'h0000_0002, 32'h0000_0002},   // R2
    {10'd1,  32'hFFFF_FFFF, 32'h0000_0000},   // R9
    {10'd1023, 32'h1234_5678, 32'h0000_0000}  // R9
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input string req, input logic [9:0] a, input logic [31:0] exp);
    addr = a; #1; chk(req, rdata, exp);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    // R1: reset state
    for (int a = 0; a < 20; a++) rd("R1", 10'(a), 32'd0);
    chk("R1 led_out", {30'd0, led_out}, 32'd0);
    chk("R1 misc_out", {24'd0, misc_out}, 32'd0);
    rst_n = 1;

    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][73:64], VEC[i][63:32]);
      rd("R2/R3/R5/R9 vector", VEC[i][73:64], VEC[i][31:0]);
    end
    chk("R2 led_out", {30'd0, led_out}, 32'd2);
    chk("R3 misc_out", {24'd0, misc_out}, 32'hA5);
    rd("R9 led unchanged", 10'd0, 32'd2);

    // R4: synchroniser latency and ignored writes
    sw_in = 8'h5A; btn_in = 2'b10;
    idle(1);
    rd("R4 switch one edge", 10'd10, 32'h00);
    idle(1);
    rd("R4 switch two edges", 10'd10, 32'h5A);
    rd("R4 button", 10'd2, 32'h2);
    wr(10'd10, 32'hFF);
    rd("R4 switch write ignored", 10'd10, 32'h5A);
    wr(10'd2, 32'h1);
    rd("R4 button write ignored", 10'd2, 32'h2);

    // R5/R6: prescaled event counter
    wr(10'd7, 32'd4);
    wr(10'd8, 32'd4);
    wr(10'd6, 32'd0);
    rd("R5 down step", 10'd8, 32'd3);
    rd("R6 event cleared", 10'd6, 32'd0);
    idle(4);
    rd("R6 first event", 10'd6, 32'd1);
    rd("R5 reload", 10'd8, 32'd4);
    idle(10);
    rd("R6 period N+1", 10'd6, 32'd3);
    idle(4);
    rd("R5 at zero", 10'd8, 32'd0);
    wr(10'd6, 32'd100);
    rd("R8 event write wins", 10'd6, 32'd100);
    rd("R5 reload beside write", 10'd8, 32'd4);
    idle(4);
    wr(10'd8, 32'd7);
    rd("R8 down write wins", 10'd8, 32'd7);
    rd("R6 step beside down write", 10'd6, 32'd101);

    // R7: rate counters
    wr(10'd5, 32'd0);
    idle(100);
    rd("R7 100Hz count", 10'd5, 32'd10);
    wr(10'd4, 32'd0);
    idle(2000);
    rd("R7 1Hz count", 10'd4, 32'd2);

    // R8: write on the 100 Hz tick edge
    begin
      logic [31:0] prev;
      addr = 10'd5; #1; prev = rdata;
      for (int k = 0; k < 20; k++) begin
        idle(1); #1;
        if (rdata != prev) break;
      end
    end
    idle(9);
    wr(10'd5, 32'd50);
    rd("R8 100Hz write wins", 10'd5, 32'd50);
    idle(9);
    rd("R7 100Hz before tick", 10'd5, 32'd50);
    idle(1);
    rd("R7 100Hz resumes", 10'd5, 32'd51);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule